// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a set of free-running clock sources and the pins that carry them off chip. Each output is a gated copy of its own source clock. A chip-wide stop request, arriving asynchronously and active low, parks every output in the low state and withdraws the request that keeps the oscillator and VCO running. Per-output enable bits can silence single outputs, and a single global bit floats all output drivers.

The stop request is brought into the reference (CPU) clock domain through a synchroniser. Power-down begins only when the synchronised request has been low on two rising edges in a row, so a one-cycle dip is ignored. Each output then obeys the decision in its own domain. A gate flop on the source's falling edge opens and closes the gate, so an output can only stop after a complete high phase and can only restart with a complete one. The output selected by a parameter runs free of its enable bit but still stops on power-down.

Top module: `clkstop_ctrl`

## Requirements
- R1: When `stop_n` is driven low just after a falling edge of `cpu_clk`, `run_req` stays 1 through the third following rising edge and drops to 0 after the fourth.
- R2: A low on `stop_n` that lasts only one `cpu_clk` cycle does not change `run_req` and stops no output.
- R3: While power-down is in effect, every bit of `clk_out` stays low, including the free-running output.
- R4: Every high pulse on `clk_out[i]` lasts exactly one high phase of `clk_src[i]`. No runt pulses occur on entry to power-down, on exit from it, or on an enable change.
- R5: After `stop_n` returns high, `run_req` returns to 1 and every enabled output toggles again.
- R6: An output `clk_out[i]` whose enable bit `en[i]` is 0 stays low. An output whose bit is 1 follows `clk_src[i]`, and bit i controls output i only.
- R7: The output at index `FREE_IDX` (default 3) toggles whatever its enable bit holds, and stops only on power-down.
- R8: While `hiz` is 1, every bit of `oe` is 0. While `hiz` is 0, every bit of `oe` is 1. `hiz` does not change the clock activity.
- R9: While `rst_n` is low, `clk_out` is all zeros and `run_req` is 1. After reset, the enabled outputs start toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Reference clock that qualifies the stop request |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| stop_n | input | 1 | Asynchronous active-low power-down request |
| clk_src | input | N_OUT | Source clocks, one per output |
| en | input | N_OUT | Per-output enable bits, where 1 lets the clock through |
| hiz | input | 1 | Global bit that floats all output drivers |
| clk_out | output | N_OUT | Gated clock outputs, parked low when stopped |
| oe | output | N_OUT | Output driver enables |
| run_req | output | 1 | Oscillator/VCO run request, 1 while not powered down |

## Verification
Four sources of different periods are gated together. Enable patterns with the free-running bit both set and cleared show whether the enables map to the right outputs and whether the free output ignores its bit. A one-cycle stop pulse is set against a sustained stop, which checks the two-edge qualification, and the exact cycle in which `run_req` falls checks the synchroniser depth. The width of every high pulse is measured for the whole run, so a runt pulse at any stop or restart is seen in whichever domain it happens.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } halt_state_e;
endpackage

// File: rtl/clkstop_rstsync.sv
module clkstop_rstsync #(
  parameter int STAGES    = 2,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_pdqual.sv
module clkstop_pdqual
  import clkstop_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_async_n,
  output logic halt
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              low_now;
  logic              low_prev_q;
  logic              low_prev_d;
  halt_state_e       state_q;
  halt_state_e       state_d;

  assign low_now = ~sync_q[STAGES-1];

  always_comb begin
    sync_d     = {sync_q[STAGES-2:0], stop_async_n};
    low_prev_d = low_now;
    state_d    = state_q;
    case (state_q)
      ST_RUN:  if (low_now && low_prev_q) state_d = ST_HALT;
      ST_HALT: if (!low_now)              state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '1;
      low_prev_q <= 1'b0;
      state_q    <= ST_RUN;
    end else begin
      sync_q     <= sync_d;
      low_prev_q <= low_prev_d;
      state_q    <= state_d;
    end
  end

  assign halt = (state_q == ST_HALT);

  // R1
  enter_after_two_lows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> ($past(low_now) && $past(low_now, 2)));

  // R2
  single_low_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && low_now && !low_prev_q) |=> !halt);

  // R5
  leave_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !low_now) |=> !halt);
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int STAGES = 2,
  parameter bit FREE   = 1'b0
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic en_async,
  input  logic halt_async,
  output logic clk_out
);
  logic              srst_n;
  logic [STAGES-1:0] en_q;
  logic [STAGES-1:0] en_d;
  logic [STAGES-1:0] halt_q;
  logic [STAGES-1:0] halt_d;
  logic              en_s;
  logic              halt_s;
  logic              gate_q;
  logic              gate_d;

  clkstop_rstsync #(.STAGES(STAGES), .FALL_EDGE(1'b1)) u_rst (
    .clk    (clk_src),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign en_s   = en_q[STAGES-1];
  assign halt_s = halt_q[STAGES-1];

  always_comb begin
    en_d   = {en_q[STAGES-2:0], en_async};
    halt_d = {halt_q[STAGES-2:0], halt_async};
    gate_d = (FREE || en_s) && !halt_s;
  end

  // Gate changes only on the falling edge, while the source is low.
  always_ff @(negedge clk_src or negedge srst_n) begin
    if (!srst_n) begin
      en_q   <= '0;
      halt_q <= '1;
      gate_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      halt_q <= halt_d;
      gate_q <= gate_d;
    end
  end

  assign clk_out = clk_src & gate_q;

  // R3
  halt_forces_off_chk: assert property (@(negedge clk_src) disable iff (!srst_n)
    halt_s |=> !gate_q);

  generate
    if (FREE) begin : g_free_chk
      // R7
      free_ignores_en_chk: assert property (@(negedge clk_src) disable iff (!srst_n)
        (!halt_s && !en_s) |=> gate_q);
    end else begin : g_en_chk
      // R6
      en_low_forces_off_chk: assert property (@(negedge clk_src) disable iff (!srst_n)
        !en_s |=> !gate_q);
    end
  endgenerate
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int N_OUT       = 4,
  parameter int FREE_IDX    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             cpu_clk,
  input  logic             rst_n,
  input  logic             stop_n,
  input  logic [N_OUT-1:0] clk_src,
  input  logic [N_OUT-1:0] en,
  input  logic             hiz,
  output logic [N_OUT-1:0] clk_out,
  output logic [N_OUT-1:0] oe,
  output logic             run_req
);
  logic cpu_rst_n;
  logic halt;

  clkstop_rstsync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_cpu_rst (
    .clk    (cpu_clk),
    .arst_n (rst_n),
    .srst_n (cpu_rst_n)
  );

  clkstop_pdqual #(.STAGES(SYNC_STAGES)) u_qual (
    .clk          (cpu_clk),
    .rst_n        (cpu_rst_n),
    .stop_async_n (stop_n),
    .halt         (halt)
  );

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      clkstop_gate #(.STAGES(SYNC_STAGES), .FREE(i == FREE_IDX)) u_gate (
        .clk_src    (clk_src[i]),
        .rst_n      (rst_n),
        .en_async   (en[i]),
        .halt_async (halt),
        .clk_out    (clk_out[i])
      );
    end
  endgenerate

  assign oe      = {N_OUT{~hiz}};
  assign run_req = ~halt;

  // R9
  reset_quiet_chk: assert property (@(posedge cpu_clk)
    !rst_n |-> (run_req && clk_out[0] == 1'b0));
endmodule

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps
module clkstop_ctrl_test;
  localparam int N = 4;

  logic         cpu_clk = 1'b0;
  logic         c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
  logic         rst_n, stop_n, hiz;
  logic [N-1:0] en;
  logic [N-1:0] clk_src;
  logic [N-1:0] clk_out, oe;
  logic         run_req;

  assign clk_src = {c3, c2, c1, cpu_clk};

  clkstop_ctrl #(.N_OUT(N), .FREE_IDX(3), .SYNC_STAGES(2)) uut (
    .cpu_clk (cpu_clk), .rst_n (rst_n), .stop_n (stop_n),
    .clk_src (clk_src), .en (en), .hiz (hiz),
    .clk_out (clk_out), .oe (oe), .run_req (run_req)
  );

  // 50 MHz reference plus three other sources
  initial forever #10 cpu_clk = ~cpu_clk;
  initial forever #20 c1 = ~c1;
  initial forever #15 c2 = ~c2;
  initial forever #30 c3 = ~c3;

  realtime half_p [N] = '{10.0, 20.0, 15.0, 30.0};

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // Edge monitor: counts rises and measures every high pulse (R4)
  logic [N-1:0] prev_out = '0;
  int           rise_cnt [N] = '{0, 0, 0, 0};
  realtime      rise_t   [N] = '{0.0, 0.0, 0.0, 0.0};
  bit           rise_ok  [N] = '{0, 0, 0, 0};
  always @(clk_out) begin
    for (int i = 0; i < N; i++) begin
      if (prev_out[i] === 1'b0 && clk_out[i] === 1'b1) begin
        rise_t[i] = $realtime; rise_ok[i] = 1'b1; rise_cnt[i]++;
      end else if (prev_out[i] === 1'b1 && clk_out[i] === 1'b0 && rise_ok[i]) begin
        realtime w;
        w = $realtime - rise_t[i];
        chk((w > half_p[i] - 0.01) && (w < half_p[i] + 0.01), $sformatf("R4 out%0d", i),
            $sformatf("%0.2f", w), $sformatf("%0.2f", half_p[i]));
      end
    end
    prev_out = clk_out;
  end

  // Scoreboard
  typedef struct {
    string        tag;
    logic [N-1:0] mask;
    logic         rr;
    logic [N-1:0] oe_exp;
  } exp_t;
  exp_t q[$];
  int pushed = 0, served = 0;

  initial begin
    forever begin
      exp_t it;
      int   base [N];
      wait (q.size() != 0);
      it = q.pop_front();
      for (int i = 0; i < N; i++) base[i] = rise_cnt[i];
      #400;
      @(negedge cpu_clk);
      for (int i = 0; i < N; i++) begin
        bit act_run;
        act_run = (rise_cnt[i] != base[i]);
        chk(act_run == it.mask[i] && (act_run || clk_out[i] === 1'b0),
            $sformatf("%s out%0d running", it.tag, i),
            $sformatf("%0b", act_run), $sformatf("%0b", it.mask[i]));
      end
      chk(run_req === it.rr, {it.tag, " run_req"}, $sformatf("%b", run_req), $sformatf("%b", it.rr));
      chk(oe === it.oe_exp, {it.tag, " oe"}, $sformatf("%b", oe), $sformatf("%b", it.oe_exp));
      served++;
    end
  end

  task automatic expect_state(input string tag, input logic [N-1:0] mask,
                              input logic rr, input logic [N-1:0] oe_exp);
    exp_t it;
    it.tag = tag; it.mask = mask; it.rr = rr; it.oe_exp = oe_exp;
    q.push_back(it);
    pushed++;
    wait (served == pushed);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #4ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; stop_n = 1'b1; hiz = 1'b0; en = '1;
    #205;
    // R9: quiet during reset
    chk(clk_out === '0, "R9 reset clk_out", $sformatf("%b", clk_out), "0000");
    chk(run_req === 1'b1, "R9 reset run_req", $sformatf("%b", run_req), "1");
    chk(oe === '1, "R8 reset oe", $sformatf("%b", oe), "1111");
    @(negedge cpu_clk) rst_n = 1'b1;
    #400;
    expect_state("R9 after reset", 4'b1111, 1'b1, 4'b1111);

    // R6/R7: outputs 1 and 3 disabled, 3 is free-running
    @(negedge cpu_clk) en = 4'b0101;
    #400;
    expect_state("R6 R7 en=0101", 4'b1101, 1'b1, 4'b1111);
    @(negedge cpu_clk) en = 4'b1010;
    #400;
    expect_state("R6 en=1010", 4'b1010, 1'b1, 4'b1111);

    // R8: floating drivers leave clocks running
    @(negedge cpu_clk) begin en = 4'b1111; hiz = 1'b1; end
    #400;
    expect_state("R8 hiz=1", 4'b1111, 1'b1, 4'b0000);
    @(negedge cpu_clk) hiz = 1'b0;
    #400;
    expect_state("R8 hiz=0", 4'b1111, 1'b1, 4'b1111);

    // R2: one-cycle dip ignored
    begin
      int drops = 0;
      @(negedge cpu_clk) stop_n = 1'b0;
      @(negedge cpu_clk) stop_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge cpu_clk);
        if (run_req !== 1'b1) drops++;
      end
      chk(drops == 0, "R2 single-cycle dip", $sformatf("%0d drops", drops), "0 drops");
    end
    #200;
    expect_state("R2 after dip", 4'b1111, 1'b1, 4'b1111);

    // R1: exact entry cycle
    @(negedge cpu_clk) stop_n = 1'b0;
    repeat (3) @(negedge cpu_clk);
    chk(run_req === 1'b1, "R1 run_req after 3 edges", $sformatf("%b", run_req), "1");
    @(negedge cpu_clk);
    chk(run_req === 1'b0, "R1 run_req after 4 edges", $sformatf("%b", run_req), "0");
    #400;
    expect_state("R3 power-down", 4'b0000, 1'b0, 4'b1111);

    // R5: leave power-down
    @(negedge cpu_clk) stop_n = 1'b1;
    #400;
    expect_state("R5 resume", 4'b1111, 1'b1, 4'b1111);

    // R7/R3: free output alone, then stopped by power-down
    @(negedge cpu_clk) en = 4'b0000;
    #400;
    expect_state("R7 en=0000", 4'b1000, 1'b1, 4'b1111);
    @(negedge cpu_clk) stop_n = 1'b0;
    #400;
    expect_state("R3 free output halted", 4'b0000, 1'b0, 4'b1111);
    @(negedge cpu_clk) begin stop_n = 1'b1; en = 4'b1111; end
    #400;
    expect_state("R5 R4 restart", 4'b1111, 1'b1, 4'b1111);

    #200;
    finish_up();
  end
endmodule